// File: doc/BRIEF.md
# Sleep Pad Output Override

This block sits between the outputs of the pad multiplexer and the pads themselves. While the `sleepEn` input is high, it can replace the output value and output enable of each pad with a configured low-power behaviour. There are four such behaviours: drive low, drive high, float, and keep what was driven last. It handles both multiplexed pads and dedicated pads. Each pad has its own 2-bit configuration register, and a shared unlock input guards every one of these registers.

An override is only allowed where it is safe. A multiplexed pad is overridden only when its select picks a constant or a peripheral flagged as able to sleep. Pads sourced from always-on peripherals keep passing their data through. Dedicated pads are marked at build time as either sleep-capable or fixed (always-on or input-only). A fixed dedicated pad has no configuration storage and is never overridden. Configuration is written and read back through a small indexed port.

Top module: `sleep_pad_override`

## Requirements
- R1: During sleep, an eligible pad with code 0 has output enable 1 and output value 0.
- R2: During sleep, an eligible pad with code 1 has output enable 1 and output value 1.
- R3: During sleep, an eligible pad with code 2 has output enable 0 and output value 0. Every configurable pad resets to code 2.
- R4: During sleep, an eligible pad with code 3 drives the value and enable it passed through in the last cycle before `sleepEn` rose. It holds them unchanged until `sleepEn` falls.
- R5: While `sleepEn` is low, every pad passes its input value and enable through unchanged. This includes the first cycle after `sleepEn` falls.
- R6: Each multiplexed pad has a select of `SelW` bits. The pad is eligible when the select is 0, 1 or 2. It is also eligible when the select is k+3 with k below `NPeriphOut` and bit k of `periphCanSleep` set. Any other select leaves the pad passing through during sleep.
- R7: A dedicated pad whose bit in `DedSleepable` is 0 is never overridden. Writes to its code are ignored, and it always reads back 0.
- R8: A write takes effect only when `cfgWe` and `cfgUnlock` are both high at the clock edge. With `cfgUnlock` low, every code stays unchanged.
- R9: `cfgRdata` shows, in the same cycle, the code of the pad that is addressed. `cfgDed`=0 selects multiplexed pad `cfgIdx` and `cfgDed`=1 selects dedicated pad `cfgIdx`. An index past the last pad reads 0, and a write to such an index is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sleepEn | input | 1 | Deep-sleep request; the override is active while high |
| cfgUnlock | input | 1 | Shared lock; configuration writes are allowed only while high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgDed | input | 1 | Address space: 0 multiplexed pads, 1 dedicated pads |
| cfgIdx | input | IdxW | Pad index within the chosen space |
| cfgWdata | input | 2 | Sleep code to write |
| cfgRdata | output | 2 | Sleep code of the addressed pad |
| muxSel | input | NMuxPads*SelW | Output select of each multiplexed pad, pad 0 in the low bits |
| periphCanSleep | input | NPeriphOut | Per-peripheral flag: 1 means the output may be overridden |
| muxOutIn | input | NMuxPads | Value from the multiplexer for each multiplexed pad |
| muxOeIn | input | NMuxPads | Enable from the multiplexer for each multiplexed pad |
| dedOutIn | input | NDedPads | Value from each dedicated peripheral output |
| dedOeIn | input | NDedPads | Enable from each dedicated peripheral output |
| muxPadOut | output | NMuxPads | Value to the multiplexed pads |
| muxPadOe | output | NMuxPads | Enable to the multiplexed pads |
| dedPadOut | output | NDedPads | Value to the dedicated pads |
| dedPadOe | output | NDedPads | Enable to the dedicated pads |

## Verification
The bench builds the block with four multiplexed pads, three dedicated pads, four peripherals and a 3-bit select, with `DedSleepable` set to 3'b101. With these values a single run reaches every class of select: the constants, a sleep-capable peripheral, an always-on peripheral, and the out-of-range select 7. It also reaches one fixed dedicated pad and one index past the end of the dedicated space, so R6, R7 and R9 are covered without a second build. Pad data is randomised every cycle, which makes sure keep mode holds the value from before sleep and does not follow the live inputs.

// File: rtl/sleep_pad_pkg.sv
package sleep_pad_pkg;

  typedef enum logic [1:0] {
    SlpLow   = 2'd0,
    SlpHigh  = 2'd1,
    SlpFloat = 2'd2,
    SlpKeep  = 2'd3
  } sleep_code_e;

  typedef struct packed {
    logic capture;  // sample pass-through state for keep mode
    logic apply;    // substitute sleep behaviour on eligible pads
  } slp_strobe_t;

endpackage

// File: rtl/sleep_pad_ctrl.sv
module sleep_pad_ctrl
  import sleep_pad_pkg::*;
#(
  parameter int NMuxPads = 8,
  parameter int NDedPads = 4,
  parameter int NPeriphOut = 8,
  parameter int SelW = 4,
  parameter logic [NDedPads-1:0] DedSleepable = '1,
  parameter int IdxW = 3,
  localparam int NPads = NMuxPads + NDedPads
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sleepEn,
  input  logic                     cfgUnlock,
  input  logic                     cfgWe,
  input  logic                     cfgDed,
  input  logic [IdxW-1:0]          cfgIdx,
  input  logic [1:0]               cfgWdata,
  output logic [1:0]               cfgRdata,
  input  logic [NMuxPads*SelW-1:0] muxSel,
  input  logic [NPeriphOut-1:0]    periphCanSleep,
  output logic [NPads-1:0][1:0]    codes,
  output logic [NPads-1:0]         eligible,
  output slp_strobe_t              strobes
);

  localparam logic [NPads-1:0] HasReg = {DedSleepable, {NMuxPads{1'b1}}};

  assign strobes.capture = !sleepEn;
  assign strobes.apply   = sleepEn;

  for (genvar p = 0; p < NPads; p++) begin : gPad
    localparam bit IsDed = (p >= NMuxPads);
    localparam int LocIdx = IsDed ? p - NMuxPads : p;

    if (HasReg[p]) begin : gReg
      logic hit;
      assign hit = cfgWe && cfgUnlock && (cfgDed == IsDed) && (cfgIdx == IdxW'(LocIdx));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    codes[p] <= SlpFloat;
        else if (hit) codes[p] <= cfgWdata;
      end
    end else begin : gFixed
      assign codes[p] = 2'd0;
    end

    if (!IsDed) begin : gMuxElig
      logic [SelW-1:0] sel;
      assign sel = muxSel[p*SelW +: SelW];
      always_comb begin
        eligible[p] = (sel < SelW'(3));
        for (int k = 0; k < NPeriphOut; k++) begin
          if (sel == SelW'(k + 3)) eligible[p] = periphCanSleep[k];
        end
      end
    end else begin : gDedElig
      assign eligible[p] = HasReg[p];
    end
  end

  always_comb begin
    cfgRdata = 2'd0;
    for (int p = 0; p < NMuxPads; p++) begin
      if (!cfgDed && cfgIdx == IdxW'(p)) cfgRdata = codes[p];
    end
    for (int d = 0; d < NDedPads; d++) begin
      if (cfgDed && cfgIdx == IdxW'(d)) cfgRdata = codes[NMuxPads + d];
    end
  end

endmodule

// File: rtl/sleep_pad_datapath.sv
module sleep_pad_datapath
  import sleep_pad_pkg::*;
#(
  parameter int NPads = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  slp_strobe_t           strobes,
  input  logic [NPads-1:0][1:0] codes,
  input  logic [NPads-1:0]      eligible,
  input  logic [NPads-1:0]      padOutIn,
  input  logic [NPads-1:0]      padOeIn,
  output logic [NPads-1:0]      padOut,
  output logic [NPads-1:0]      padOe
);

  logic [NPads-1:0] keepOut, keepOe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keepOut <= '0;
      keepOe  <= '0;
    end else if (strobes.capture) begin
      keepOut <= padOutIn;
      keepOe  <= padOeIn;
    end
  end

  always_comb begin
    padOut = padOutIn;
    padOe  = padOeIn;
    for (int p = 0; p < NPads; p++) begin
      if (strobes.apply && eligible[p]) begin
        case (sleep_code_e'(codes[p]))
          SlpLow:   begin padOut[p] = 1'b0;       padOe[p] = 1'b1;      end
          SlpHigh:  begin padOut[p] = 1'b1;       padOe[p] = 1'b1;      end
          SlpFloat: begin padOut[p] = 1'b0;       padOe[p] = 1'b0;      end
          default:  begin padOut[p] = keepOut[p]; padOe[p] = keepOe[p]; end
        endcase
      end
    end
  end

endmodule

// File: rtl/sleep_pad_override.sv
module sleep_pad_override
  import sleep_pad_pkg::*;
#(
  parameter int NMuxPads = 8,
  parameter int NDedPads = 4,
  parameter int NPeriphOut = 8,
  parameter int SelW = 4,
  parameter logic [NDedPads-1:0] DedSleepable = '1,
  localparam int MaxPads = (NMuxPads > NDedPads) ? NMuxPads : NDedPads,
  localparam int IdxW = (MaxPads > 1) ? $clog2(MaxPads) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sleepEn,
  input  logic                     cfgUnlock,
  input  logic                     cfgWe,
  input  logic                     cfgDed,
  input  logic [IdxW-1:0]          cfgIdx,
  input  logic [1:0]               cfgWdata,
  output logic [1:0]               cfgRdata,
  input  logic [NMuxPads*SelW-1:0] muxSel,
  input  logic [NPeriphOut-1:0]    periphCanSleep,
  input  logic [NMuxPads-1:0]      muxOutIn,
  input  logic [NMuxPads-1:0]      muxOeIn,
  input  logic [NDedPads-1:0]      dedOutIn,
  input  logic [NDedPads-1:0]      dedOeIn,
  output logic [NMuxPads-1:0]      muxPadOut,
  output logic [NMuxPads-1:0]      muxPadOe,
  output logic [NDedPads-1:0]      dedPadOut,
  output logic [NDedPads-1:0]      dedPadOe
);

  localparam int NPads = NMuxPads + NDedPads;

  logic [NPads-1:0][1:0] codes;
  logic [NPads-1:0]      eligible;
  logic [NPads-1:0]      allOutIn, allOeIn, allOut, allOe;
  slp_strobe_t           strobes;

  assign allOutIn = {dedOutIn, muxOutIn};
  assign allOeIn  = {dedOeIn, muxOeIn};
  assign {dedPadOut, muxPadOut} = allOut;
  assign {dedPadOe, muxPadOe}   = allOe;

  sleep_pad_ctrl #(
    .NMuxPads(NMuxPads), .NDedPads(NDedPads), .NPeriphOut(NPeriphOut),
    .SelW(SelW), .DedSleepable(DedSleepable), .IdxW(IdxW)
  ) u_ctrl (
    .clk, .rstN, .sleepEn, .cfgUnlock, .cfgWe, .cfgDed, .cfgIdx, .cfgWdata,
    .cfgRdata, .muxSel, .periphCanSleep, .codes, .eligible, .strobes
  );

  sleep_pad_datapath #(.NPads(NPads)) u_dp (
    .clk, .rstN, .strobes, .codes, .eligible,
    .padOutIn(allOutIn), .padOeIn(allOeIn), .padOut(allOut), .padOe(allOe)
  );

endmodule

// File: rtl/sleep_pad_override_chk.sv
module sleep_pad_override_chk #(
  parameter int NMuxPads = 8,
  parameter int NDedPads = 4,
  parameter logic [NDedPads-1:0] DedSleepable = '1,
  localparam int NPads = NMuxPads + NDedPads
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sleepEn,
  input logic                  cfgUnlock,
  input logic [NPads-1:0][1:0] codes,
  input logic [NPads-1:0]      eligible,
  input logic [NPads-1:0]      allOutIn,
  input logic [NPads-1:0]      allOeIn,
  input logic [NPads-1:0]      allOut,
  input logic [NPads-1:0]      allOe
);

  AST_LOCK_HOLDS_CODES: assert property (@(posedge clk) disable iff (!rstN)
    !cfgUnlock |=> $stable(codes)); // R8

  for (genvar p = 0; p < NPads; p++) begin : gChk
    AST_CODE0_LOW: assert property (@(posedge clk) disable iff (!rstN)
      sleepEn && eligible[p] && codes[p] == 2'd0 |-> allOe[p] && !allOut[p]); // R1
    AST_CODE1_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      sleepEn && eligible[p] && codes[p] == 2'd1 |-> allOe[p] && allOut[p]); // R2
    AST_CODE2_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
      sleepEn && eligible[p] && codes[p] == 2'd2 |-> !allOe[p] && !allOut[p]); // R3
    AST_KEEP_STEADY: assert property (@(posedge clk) disable iff (!rstN)
      sleepEn && $past(sleepEn) && eligible[p] && $past(eligible[p])
        && codes[p] == 2'd3 && $past(codes[p]) == 2'd3
      |-> $stable(allOut[p]) && $stable(allOe[p])); // R4
    AST_AWAKE_PASS: assert property (@(posedge clk) disable iff (!rstN)
      !sleepEn |-> allOut[p] == allOutIn[p] && allOe[p] == allOeIn[p]); // R5
    AST_INELIGIBLE_PASS: assert property (@(posedge clk) disable iff (!rstN)
      !eligible[p] |-> allOut[p] == allOutIn[p] && allOe[p] == allOeIn[p]); // R6
    if (p >= NMuxPads) begin : gDed
      if (!DedSleepable[p - NMuxPads]) begin : gFixed
        AST_FIXED_DED_PASS: assert property (@(posedge clk) disable iff (!rstN)
          sleepEn |-> allOut[p] == allOutIn[p] && allOe[p] == allOeIn[p]); // R7
      end
    end
  end

endmodule

bind sleep_pad_override sleep_pad_override_chk #(
  .NMuxPads(NMuxPads), .NDedPads(NDedPads), .DedSleepable(DedSleepable)
) u_chk (
  .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .cfgUnlock(cfgUnlock),
  .codes(codes), .eligible(eligible), .allOutIn(allOutIn), .allOeIn(allOeIn),
  .allOut(allOut), .allOe(allOe)
);

// File: tb/sleep_pad_override_tb.sv
module sleep_pad_override_tb;

  localparam int NM = 4, ND = 3, NP = 4, SW = 3, NT = NM + ND;
  localparam logic [ND-1:0] DS = 3'b101;

  logic clk = 0, rstN = 0, sleepEn = 0, cfgUnlock = 1, cfgWe = 0, cfgDed = 0;
  logic [1:0] cfgIdx = 0, cfgWdata = 0, cfgRdata;
  logic [NM*SW-1:0] muxSel = '0;
  logic [NP-1:0] periphCanSleep = '0;
  logic [NM-1:0] muxOutIn = 0, muxOeIn = 0, muxPadOut, muxPadOe;
  logic [ND-1:0] dedOutIn = 0, dedOeIn = 0, dedPadOut, dedPadOe;

  int errors = 0, checks = 0;
  bit done = 0;
  int mCode[NT];
  bit mKeepO[NT], mKeepE[NT];

  always #10 clk = ~clk;  // 50 MHz

  sleep_pad_override #(.NMuxPads(NM), .NDedPads(ND), .NPeriphOut(NP), .SelW(SW),
    .DedSleepable(DS)) u_dut (.*);

  function automatic bit hasReg(int p);
    return (p < NM) || DS[p - NM];
  endfunction

  function automatic bit inO(int p);
    return (p < NM) ? muxOutIn[p] : dedOutIn[p - NM];
  endfunction

  function automatic bit inE(int p);
    return (p < NM) ? muxOeIn[p] : dedOeIn[p - NM];
  endfunction

  // behavioural reference state
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NT; p++) begin
        mCode[p] = hasReg(p) ? 2 : 0; mKeepO[p] = 0; mKeepE[p] = 0;
      end
    end else begin
      if (cfgWe && cfgUnlock) begin
        int t;
        t = cfgDed ? ((cfgIdx < ND) ? NM + cfgIdx : -1) : ((cfgIdx < NM) ? int'(cfgIdx) : -1);
        if (t >= 0 && hasReg(t)) mCode[t] = cfgWdata;
      end
      if (!sleepEn) for (int p = 0; p < NT; p++) begin mKeepO[p] = inO(p); mKeepE[p] = inE(p); end
    end
  end

  task automatic checkAll();
    for (int p = 0; p < NT; p++) begin
      bit eo, ee, elig, ao, ae;
      string tag;
      int s;
      eo = inO(p); ee = inE(p);
      if (p < NM) begin
        s = int'(muxSel[p*SW +: SW]);
        elig = (s < 3) || (s - 3 < NP && periphCanSleep[s - 3]);
      end else elig = DS[p - NM];
      if (!sleepEn) tag = "R5";
      else if (!elig) tag = (p < NM) ? "R6" : "R7";
      else case (mCode[p])
        0: begin tag = "R1"; eo = 0; ee = 1; end
        1: begin tag = "R2"; eo = 1; ee = 1; end
        2: begin tag = "R3"; eo = 0; ee = 0; end
        default: begin tag = "R4"; eo = mKeepO[p]; ee = mKeepE[p]; end
      endcase
      ao = (p < NM) ? muxPadOut[p] : dedPadOut[p - NM];
      ae = (p < NM) ? muxPadOe[p] : dedPadOe[p - NM];
      checks++;
      if (ao !== eo || ae !== ee) begin
        errors++;
        $display("FAIL %s pad %0d: out/oe actual %b%b expected %b%b", tag, p, ao, ae, eo, ee);
      end
    end
    begin
      int t, ex;
      t = cfgDed ? ((cfgIdx < ND) ? NM + cfgIdx : -1) : ((cfgIdx < NM) ? int'(cfgIdx) : -1);
      ex = (t >= 0) ? mCode[t] : 0;
      checks++;
      if (int'(cfgRdata) != ex) begin
        errors++;
        $display("FAIL R9 readback ded=%0d idx=%0d: actual %0d expected %0d",
                 cfgDed, cfgIdx, cfgRdata, ex);
      end
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk); #5;
      checkAll();
      muxOutIn = NM'($urandom); muxOeIn = NM'($urandom);
      dedOutIn = ND'($urandom); dedOeIn = ND'($urandom);
    end
  endtask

  task automatic wr(bit ded, int idx, int val);
    cfgWe = 1; cfgDed = ded; cfgIdx = 2'(idx); cfgWdata = 2'(val);
    tick();
    cfgWe = 0;
  endtask

  task automatic readAll();
    for (int p = 0; p < NT; p++) begin
      cfgDed = (p >= NM); cfgIdx = 2'((p < NM) ? p : p - NM);
      tick();
    end
  endtask

  task automatic setSel(int s0, int s1, int s2, int s3);
    muxSel = {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rstN = 1;
    // reset codes: 2 on configurable pads, 0 on fixed dedicated pad (R3, R7)
    readAll();
    // R1 R2 R4 with constants and one sleep-capable peripheral
    setSel(0, 1, 2, 3); periphCanSleep = 4'b0001;
    wr(0, 0, 0); wr(0, 1, 1); wr(0, 2, 3); wr(0, 3, 3);
    wr(1, 0, 0); wr(1, 1, 3); wr(1, 2, 1);
    readAll();
    tick(3);
    sleepEn = 1; tick(6);
    sleepEn = 0; tick(3);       // R5 immediate resume
    // R6: always-on peripheral and out-of-range select stay live
    setSel(4, 7, 5, 2); periphCanSleep = 4'b0100;
    sleepEn = 1; tick(5);
    periphCanSleep = 4'b0110; tick(2);
    sleepEn = 0; tick(2);
    // R8: writes with lock cleared
    cfgUnlock = 0;
    wr(0, 0, 2); wr(0, 3, 1); wr(1, 2, 2);
    readAll();
    sleepEn = 1; tick(4); sleepEn = 0; tick();
    cfgUnlock = 1;
    // R9: write to index past dedicated pads, then float everywhere
    wr(1, 3, 1);
    cfgDed = 1; cfgIdx = 3; tick();
    for (int p = 0; p < NM; p++) wr(0, p, 2);
    wr(1, 0, 2); wr(1, 2, 3);
    setSel(0, 1, 2, 3);
    sleepEn = 1; tick(); sleepEn = 0; tick();
    sleepEn = 1; tick(4); sleepEn = 0; tick(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule